// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Port with Nine-Bit Mode

This block is a full-duplex asynchronous serial port. It has a transmitter and a receiver, and both are paced by a shared baud tick that runs at sixteen times the bit rate. A frame is either ten bits long (start, eight data bits, stop) or eleven bits long (start, eight data bits, a ninth bit, stop). Data always travels least significant bit first.

The receiver passes the line through a synchronizer and waits for a falling edge. On that edge it clears its oversample counter, so the counter's rollovers fall on the bit boundaries. It then decides the start bit and every later bit by a two-out-of-three vote over three samples taken in the middle of the bit. If the start bit is not confirmed low, the receiver drops the frame and waits for the next edge. A received frame goes to a holding register and raises the receive flag. A frame that completes while the flag is still set is dropped. In nine-bit mode an optional address filter accepts only frames whose ninth bit is 1.

A write to the transmitter arms it. Shifting starts on the first rollover of the free-running transmit oversample counter after the write. The transmit flag rises when the stop bit begins. Each flag stays set until its own clear strobe.

States:
- Transmitter: `T_IDLE`, `T_ARMED` and `T_SEND`.
  - `T_IDLE -> T_ARMED` on a write.
  - `T_ARMED -> T_SEND` on a rollover.
  - `T_SEND -> T_IDLE` on the rollover that ends the stop bit.
- Receiver: `R_IDLE`, `R_START`, `R_DATA`, `R_NINTH` and `R_STOP`.
  - `R_IDLE -> R_START` on an enabled falling edge.
  - `R_START -> R_DATA` on a low vote; `R_START -> R_IDLE` on a high vote.
  - `R_DATA -> R_NINTH` (nine-bit mode) or `R_DATA -> R_STOP` after the eighth bit.
  - `R_NINTH -> R_STOP` after its vote.
  - `R_STOP -> R_IDLE` at the vote in the middle of the stop bit.

Top module: `vote_uart`

## Requirements
- R1: After reset, `txd` is 1, `ti` and `ri` are 0, and `rx_data` is 0.
- R2: A write (`tx_wr`) is accepted only while the transmitter is idle, and writes made while it is busy are ignored. The start bit begins on the first baud tick after the write on which the transmit oversample count (ticks since reset, modulo 16) rolls over from 15.
- R3: The transmitter sends, in this order and for 16 ticks each:
  - a start bit of 0;
  - the data byte, LSB first;
  - `tx_bit9`, only when `nine_mode` was 1 at the write;
  - a stop bit of 1.
- R4: `ti` rises in the cycle the stop bit begins. It stays set until `ti_clr` is pulsed, and then reads 0.
- R5: Each received bit is the majority of three line samples, taken at oversample counts 7, 8 and 9 after the start edge. A wrong value in one sample does not change the bit.
- R6: If the start-bit vote is 1, the frame is dropped without setting `ri`, and the next falling edge starts a new frame.
- R7: In ten-bit mode (`nine_mode` = 0), the received stop bit is stored in `rx_bit9`, whether it is 1 or 0.
- R8: In nine-bit mode, the received ninth bit is stored in `rx_bit9`. With `addr_filter` = 1, a frame whose ninth bit is 0 leaves `ri` and `rx_data` untouched.
- R9: When a frame completes at the stop-bit vote while `ri` is clear, it loads `rx_data` and `rx_bit9` and sets `ri`. While `ri` is set, a completed frame is dropped and `rx_data` stays unchanged. `ri_clr` clears `ri`.
- R10: While `rx_en` is 0, falling edges on `rxd` start no reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line |
| tx_wr | input | 1 | Transmit write strobe |
| tx_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send in nine-bit mode |
| rx_en | input | 1 | Receive enable |
| nine_mode | input | 1 | 1 selects the eleven-bit frame |
| addr_filter | input | 1 | Accept only frames with ninth bit 1 (nine-bit mode) |
| ti_clr | input | 1 | Clears the transmit flag |
| ri_clr | input | 1 | Clears the receive flag |
| txd | output | 1 | Serial transmit line |
| rx_data | output | 8 | Holding register, received byte |
| rx_bit9 | output | 1 | Received ninth bit, or the stop bit in ten-bit mode |
| ti | output | 1 | Transmit flag |
| ri | output | 1 | Receive flag |

## Verification
The transmitter's start bit appears in the same clock edge as the rollover tick. The bench counts baud ticks itself and requires the start bit to appear on a tick count that is a multiple of 16, no more than 17 ticks after the write. It then samples each transmitted bit 32 cycles into its 64-cycle span.

The receiver's flag rises about 34 to 42 cycles into the stop bit: roughly three cycles of synchronizer and edge logic, plus ten ticks of four cycles each. The bench therefore compares received results only once the full stop bit has been driven, and it checks flags that must stay low only after a whole frame time has passed.

// File: rtl/vote_uart_pkg.sv
package vote_uart_pkg;
    typedef enum logic [1:0] {T_IDLE, T_ARMED, T_SEND} tx_state_e;
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_NINTH, R_STOP} rx_state_e;
endpackage

// File: rtl/vote_uart_tx.sv
module vote_uart_tx
    import vote_uart_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          wr,
    input  logic [DW-1:0] data,
    input  logic          bit9,
    input  logic          nine,
    input  logic          ti_clr,
    output logic          txd,
    output logic          ti
);
    localparam int DIVW = $clog2(OSR);
    localparam int FW   = DW + 3;
    localparam int CW   = $clog2(FW + 1);

    tx_state_e       st_q, st_d;
    logic [DIVW-1:0] div_q;
    logic [FW-1:0]   sh_q;
    logic [CW-1:0]   cnt_q, last_q;
    logic            ti_q;
    logic            roll;

    assign roll = baud_tick && (div_q == DIVW'(OSR - 1));

    // free-running oversample counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         div_q <= '0;
        else if (baud_tick) div_q <= roll ? '0 : div_q + 1'b1;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            T_IDLE:  if (wr) st_d = T_ARMED;
            T_ARMED: if (roll) st_d = T_SEND;
            T_SEND:  if (roll && cnt_q == last_q) st_d = T_IDLE;
            default: st_d = T_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= T_IDLE;
        else        st_q <= st_d;
    end

    // frame shifter and transmit flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '1;
            cnt_q  <= '0;
            last_q <= '0;
            ti_q   <= 1'b0;
        end else begin
            if (st_q == T_IDLE && wr) begin
                sh_q   <= nine ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
                last_q <= nine ? CW'(FW - 1) : CW'(FW - 2);
                cnt_q  <= '0;
            end else if (st_q == T_SEND && roll) begin
                sh_q  <= {1'b1, sh_q[FW-1:1]};
                cnt_q <= cnt_q + 1'b1;
            end
            if (st_q == T_SEND && roll && cnt_q == last_q - 1'b1) ti_q <= 1'b1;
            else if (ti_clr)                                     ti_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        txd = (st_q == T_SEND) ? sh_q[0] : 1'b1;
        ti  = ti_q;
    end

    // R4: the flag rises while the line carries the stop level
    p_ti_at_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ti) |-> txd);
    // R2: the line is marking whenever no frame is in progress
    p_idle_marking_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != T_SEND) |-> txd);
    // R2: a write made while busy leaves the frame untouched
    p_busy_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_SEND && wr && !roll) |=> $stable(sh_q));
endmodule

// File: rtl/vote_uart_rx.sv
module vote_uart_rx
    import vote_uart_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          rxd,
    input  logic          rx_en,
    input  logic          nine,
    input  logic          filt,
    input  logic          ri_clr,
    output logic [DW-1:0] data,
    output logic          bit9,
    output logic          ri
);
    localparam int DIVW = $clog2(OSR);
    localparam int BW   = $clog2(DW);
    localparam int MID  = OSR / 2;

    rx_state_e       st_q, st_d;
    logic [2:0]      sy_q;
    logic [DIVW-1:0] div_q;
    logic [1:0]      samp_q;
    logic [BW-1:0]   bit_q;
    logic [DW-1:0]   sh_q, data_q;
    logic            b9_q, bit9_q, ri_q;
    logic            rx_s, fall, vote_now, vote, fin_b9, deliver;

    assign rx_s     = sy_q[1];
    assign fall     = sy_q[2] && !rx_s;
    assign vote_now = baud_tick && (st_q != R_IDLE) && (div_q == DIVW'(MID + 1));
    assign vote     = (samp_q[1] & samp_q[0]) | (samp_q[1] & rx_s) | (samp_q[0] & rx_s);
    assign fin_b9   = nine ? b9_q : vote;
    assign deliver  = (st_q == R_STOP) && vote_now && !ri_q && !(nine && filt && !fin_b9);

    // synchronizer, edge history, oversample counter, sample window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q   <= 3'b111;
            div_q  <= '0;
            samp_q <= 2'b11;
        end else begin
            sy_q <= {sy_q[1:0], rxd};
            if (st_q == R_IDLE) div_q <= '0;
            else if (baud_tick) div_q <= div_q + 1'b1;
            if (baud_tick && (div_q == DIVW'(MID - 1) || div_q == DIVW'(MID)))
                samp_q <= {samp_q[0], rx_s};
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            R_IDLE:  if (rx_en && fall) st_d = R_START;
            R_START: if (vote_now) st_d = vote ? R_IDLE : R_DATA;
            R_DATA:  if (vote_now && bit_q == BW'(DW - 1)) st_d = nine ? R_NINTH : R_STOP;
            R_NINTH: if (vote_now) st_d = R_STOP;
            R_STOP:  if (vote_now) st_d = R_IDLE;
            default: st_d = R_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= R_IDLE;
        else        st_q <= st_d;
    end

    // shifter, holding register and receive flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            sh_q   <= '0;
            b9_q   <= 1'b0;
            data_q <= '0;
            bit9_q <= 1'b0;
            ri_q   <= 1'b0;
        end else begin
            if (vote_now) begin
                if (st_q == R_START) bit_q <= '0;
                if (st_q == R_DATA) begin
                    sh_q  <= {vote, sh_q[DW-1:1]};
                    bit_q <= bit_q + 1'b1;
                end
                if (st_q == R_NINTH) b9_q <= vote;
            end
            if (deliver) begin
                data_q <= sh_q;
                bit9_q <= fin_b9;
                ri_q   <= 1'b1;
            end else if (ri_clr) begin
                ri_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        data = data_q;
        bit9 = bit9_q;
        ri   = ri_q;
    end

    // R8: with the filter on, only frames with ninth bit 1 raise the flag
    p_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nine && filt && $rose(ri)) |-> bit9);
    // R9: the holding register keeps its byte while the flag is set
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && $past(ri)) |-> (data == $past(data)));
    // R10: a disabled receiver stays idle
    p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && st_q == R_IDLE) |=> (st_q == R_IDLE));
    // R6: a rejected start bit never raises the flag in the next cycle
    p_false_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == R_START && vote_now && vote && !ri) |=> !ri);
endmodule

// File: rtl/vote_uart.sv
module vote_uart #(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          rxd,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_bit9,
    input  logic          rx_en,
    input  logic          nine_mode,
    input  logic          addr_filter,
    input  logic          ti_clr,
    input  logic          ri_clr,
    output logic          txd,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          ti,
    output logic          ri
);
    vote_uart_tx #(.OSR(OSR), .DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr(tx_wr),
        .data(tx_data), .bit9(tx_bit9), .nine(nine_mode), .ti_clr(ti_clr),
        .txd(txd), .ti(ti)
    );

    vote_uart_rx #(.OSR(OSR), .DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .rx_en(rx_en), .nine(nine_mode), .filt(addr_filter), .ri_clr(ri_clr),
        .data(rx_data), .bit9(rx_bit9), .ri(ri)
    );

    // R1: no flag is raised in the first cycle after reset
    p_reset_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ti && !ri));
endmodule

// File: tb/sim_vote_uart.sv
`timescale 1ns/1ps
module sim_vote_uart;
    logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1;
    logic tx_wr = 1'b0, tx_bit9 = 1'b0, rx_en = 1'b0, nine_mode = 1'b0, addr_filter = 1'b0;
    logic ti_clr = 1'b0, ri_clr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic txd, rx_bit9, ti, ri;
    logic [7:0] rx_data;

    int checks = 0, errors = 0, tcount = 0, tx_sent = 0, tx_done = 0;
    bit keep_ri = 1'b0, finished = 1'b0;
    logic [8:0] rxq[$];
    logic [9:0] txq[$];
    int twq[$];

    vote_uart u0 (.*);

    always #5 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    always @(posedge clk) if (rst_n && baud_tick) tcount <= tcount + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // receive-side driver
    task automatic drive_bit(input logic v, input bit g);
        rxd = v;
        repeat (36) @(negedge clk);
        if (g) rxd = ~v;
        repeat (3) @(negedge clk);
        rxd = v;
        repeat (25) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input logic b9, input logic use9,
                            input logic stopv, input bit glitch, input bit expect_it);
        if (expect_it) rxq.push_back({use9 ? b9 : stopv, d});
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i], glitch);
        if (use9) drive_bit(b9, glitch);
        drive_bit(stopv, 1'b0);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
    endtask

    // receive-side monitor
    initial begin
        bit seen = 1'b0;
        logic [8:0] e;
        forever begin
            @(negedge clk);
            ri_clr = 1'b0;
            if (rst_n && ri && !seen) begin
                seen = 1'b1;
                if (rxq.size() == 0) chk(1'b0, "R9 unexpected ri", {rx_bit9, rx_data}, 0);
                else begin
                    e = rxq.pop_front();
                    chk({rx_bit9, rx_data} == e, "R5/R7/R8 received frame", {rx_bit9, rx_data}, e);
                end
            end
            if (rst_n && ri && !keep_ri) begin
                ri_clr = 1'b1;
                seen = 1'b0;
            end
        end
    end

    // transmit-side driver
    task automatic tx_send(input logic [7:0] d, input logic b9);
        wait (tx_done == tx_sent);
        @(negedge clk);
        tx_data = d;
        tx_bit9 = b9;
        tx_wr = 1'b1;
        txq.push_back({nine_mode, b9, d});
        twq.push_back(tcount);
        @(negedge clk);
        tx_wr = 1'b0;
        tx_sent++;
    endtask

    // transmit-side monitor
    initial begin
        logic [9:0] it;
        logic [8:0] got, exp_bits;
        logic t_before, t_stop, stopv;
        int wt, nb;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                if (txq.size() == 0) begin
                    chk(1'b0, "R2 frame without accepted write", 1, 0);
                    repeat (800) @(negedge clk);
                end else begin
                    it = txq.pop_front();
                    wt = twq.pop_front();
                    chk((tcount % 16 == 0) && (tcount - wt <= 17), "R2 start on first rollover",
                        tcount - wt, 16);
                    repeat (32) @(negedge clk);
                    chk(txd == 1'b0, "R3 start bit", txd, 0);
                    nb = it[9] ? 9 : 8;
                    got = '0;
                    t_before = 1'b0;
                    for (int i = 0; i < nb; i++) begin
                        repeat (64) @(negedge clk);
                        got[i] = txd;
                        if (i == nb - 1) t_before = ti;
                    end
                    repeat (64) @(negedge clk);
                    stopv = txd;
                    t_stop = ti;
                    exp_bits = it[9] ? it[8:0] : {1'b0, it[7:0]};
                    chk(got == exp_bits, "R3 data and ninth bit order", got, exp_bits);
                    chk(stopv == 1'b1, "R3 stop bit", stopv, 1);
                    chk(t_before == 1'b0 && t_stop == 1'b1, "R4 ti at stop start",
                        {t_before, t_stop}, 1);
                    ti_clr = 1'b1;
                    @(negedge clk);
                    ti_clr = 1'b0;
                    @(negedge clk);
                    chk(ti == 1'b0, "R4 ti cleared", ti, 0);
                    repeat (40) @(negedge clk);
                    tx_done++;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(ti == 1'b0, "R1 ti", ti, 0);
        chk(ri == 1'b0, "R1 ri", ri, 0);
        chk(rx_data == 8'h00, "R1 rx_data", rx_data, 0);

        rx_en = 1'b1;
        repeat (20) @(negedge clk);
        rx_frame(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);   // R7 stop 1
        rx_frame(8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);   // R5 single-sample glitches
        rx_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);   // R7 stop 0 stored

        // R6 false start
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (800) @(negedge clk);
        chk(ri == 1'b0, "R6 false start raises no ri", ri, 0);
        rx_frame(8'h81, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);

        // R10 receiver disabled
        rx_en = 1'b0;
        rx_frame(8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(ri == 1'b0, "R10 disabled receiver", ri, 0);
        rx_en = 1'b1;

        // R8 nine-bit mode and filter
        nine_mode = 1'b1;
        rx_frame(8'h12, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        addr_filter = 1'b1;
        rx_frame(8'h34, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(ri == 1'b0, "R8 filtered frame raises no ri", ri, 0);
        rx_frame(8'h56, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        addr_filter = 1'b0;
        nine_mode = 1'b0;

        // R9 drop while ri set
        keep_ri = 1'b1;
        rx_frame(8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        rx_frame(8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(ri == 1'b1 && rx_data == 8'h11, "R9 second frame dropped", rx_data, 8'h11);
        keep_ri = 1'b0;
        repeat (5) @(negedge clk);
        chk(ri == 1'b0, "R9 ri_clr clears", ri, 0);
        rx_frame(8'h33, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);

        // transmitter
        tx_send(8'hC3, 1'b0);
        repeat (200) @(negedge clk);
        tx_wr = 1'b1;                 // R2 write while busy, ignored
        tx_data = 8'h00;
        @(negedge clk);
        tx_wr = 1'b0;
        nine_mode = 1'b1;
        tx_send(8'h96, 1'b1);
        tx_send(8'h0F, 1'b0);
        wait (tx_done == tx_sent);
        nine_mode = 1'b0;
        repeat (1000) @(negedge clk);
        chk(txd == 1'b1, "R2 line idle after busy write", txd, 1);
        chk(txq.size() == 0 && rxq.size() == 0, "R3/R9 scoreboard drained",
            txq.size() + rxq.size(), 0);
        summary();
    end
endmodule